// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

This block runs lists of analog conversion commands that software keeps in a table of 64 command slots, and it files every returned sample in a result slot with the same index. The table is split between two queues. The first queue always starts at slot 0. The second queue starts at a slot chosen by the `q2_base` input. Each queue is armed by its own trigger, which comes either from software or from an external pulse, as selected by its mode. Once armed, the queue walks its slots in order. For each slot it sends a single-cycle start to the converter, carrying the channel, the reference select and the sample-time code, and then waits for the converter's done pulse.

A command can carry a pause flag. The queue then stops after that conversion and continues at the next slot when the next trigger arrives. A queue finishes when it meets the end code, when it reaches the start of the second queue (first queue only), or when it passes the last slot. It then pulses its completion output. Software reads commands and results through one bus port whose address is split into a 2-bit window and a 6-bit slot index. The window selects the command word or one of three 16-bit views of the 10-bit result.

Two small state machines do the sequencing. Each queue has one controller with the states QS_IDLE, QS_RUN and QS_PAUSE:
- An accepted trigger moves QS_IDLE to QS_RUN and reloads the queue pointer.
- A finished pause command moves QS_RUN to QS_PAUSE.
- An accepted trigger moves QS_PAUSE back to QS_RUN.
- A detected end moves QS_RUN to QS_IDLE.

A shared sequencer has the states SQ_PICK and SQ_WAIT:
- An issued command moves SQ_PICK to SQ_WAIT.
- A done pulse from the converter moves SQ_WAIT back to SQ_PICK.

Top module: `adcq_seq`

## Requirements
- R1: A write to window 0 (address bits 7:6 = 0) stores the low 10 bits of the bus data as the command for the slot in bits 5:0. Command bit 9 is pause, bit 8 is the alternate-reference select, bits 7:6 are the sample-time code and bits 5:0 are the channel. A read of window 0 returns the command with bits 15:10 zero.
- R2: A bus write to windows 1, 2 or 3 leaves every stored result unchanged.
- R3: The mode encodings are 0 = disabled, 1 = software trigger (`sw_go`) and 2 = external trigger (`ext_trig`). A disabled queue ignores both pulses, and an enabled queue ignores the pulse that its mode does not select.
- R4: After a trigger, the queue's first command (slot 0 for the first queue, slot `q2_base` for the second queue) is issued as a one-cycle `conv_start`, with `conv_chan`, `conv_ref` and `conv_ist` taken from that command. Later commands follow in slot order.
- R5: The 10-bit result of a conversion is stored at the slot of its command. Window 1 reads it right-justified with bits 15:10 zero. Window 2 reads it in bits 15:6 with bits 5:0 zero. Window 3 reads it in bits 15:6 with bit 15 inverted and bits 5:0 zero.
- R6: After a command with the pause bit set completes, the queue issues nothing more until its next accepted trigger. The queue then resumes at the following slot.
- R7: A command whose channel is 63 is not converted. It ends the queue, which pulses its `q_done` bit for one cycle.
- R8: The first queue also ends on reaching slot `q2_base`, and any `q2_base` of 64 or more gives it all 64 slots. The second queue ends after slot 63, and `q2_base` = 0 gives it all 64 slots.
- R9: When both queues are running, the first queue's commands are issued first. The second queue proceeds once the first queue has finished or paused.
- R10: No new `conv_start` is raised while a conversion awaits its done pulse.
- R11: After reset no start or completion pulse is raised, and all command and result slots read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Window in bits 7:6, slot index in bits 5:0 |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| q1_mode | input | 2 | First queue mode: 0 off, 1 software, 2 external |
| q2_mode | input | 2 | Second queue mode, same encoding |
| q2_base | input | 7 | First slot of the second queue, clipped to 64 |
| sw_go | input | 2 | Software trigger pulse per queue (bit 0 = first queue) |
| ext_trig | input | 2 | External trigger pulse per queue |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 6 | Channel for the started conversion |
| conv_ref | output | 1 | Alternate reference select |
| conv_ist | output | 2 | Sample-time code |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| q_done | output | 2 | One-cycle completion pulse per queue |

## Verification
A queue pointer that goes wrong shows on the very next `conv_start` as a wrong channel. It also shows as a result stored in the wrong slot, which a window read detects as soon as the queue ends. A queue controller stuck in the wrong state shows within a few cycles of a trigger: either a start is missing, or a start appears during a pause or after an end code, or the `q_done` pulse is absent. A wrong sequencer state shows at the converter port as a second start before done or as a missing start. A formatting slip shows on the first read of any result window.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_SW   = 2'd1,
        MODE_EXT  = 2'd2,
        MODE_RSVD = 2'd3
    } qmode_e;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,
        QS_RUN   = 2'd1,
        QS_PAUSE = 2'd2
    } qstate_e;

    typedef enum logic {
        SQ_PICK = 1'b0,
        SQ_WAIT = 1'b1
    } seq_e;

    typedef struct packed {
        logic       pause;
        logic       ref_alt;
        logic [1:0] ist;
        logic [5:0] chan;
    } cmd_t;

    localparam int         CMD_W    = $bits(cmd_t);
    localparam logic [5:0] END_CODE = 6'd63;

endpackage

// File: rtl/adcq_store.sv
module adcq_store
    import adcq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AW    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  cmd_idx,
    output cmd_t              cmd_word,
    input  logic              res_we,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [RES_W-1:0]  res_val
);

    localparam int PAD_C = DATA_W - CMD_W;
    localparam int PAD_R = DATA_W - RES_W;

    cmd_t             cmd_mem [DEPTH];
    logic [RES_W-1:0] res_mem [DEPTH];

    logic [1:0]       win;
    logic [IDX_W-1:0] slot;
    logic [RES_W-1:0] rsel;

    assign win  = bus_addr[AW-1:AW-2];
    assign slot = bus_addr[IDX_W-1:0];
    assign rsel = res_mem[slot];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cmd_mem[i] <= '0;
                res_mem[i] <= '0;
            end
        end else begin
            if (bus_wr && win == 2'd0)
                cmd_mem[slot] <= cmd_t'(bus_wdata[CMD_W-1:0]);
            if (res_we)
                res_mem[res_idx] <= res_val;
        end
    end

    assign cmd_word = cmd_mem[cmd_idx];

    always_comb begin
        unique case (win)
            2'd0: bus_rdata = {{PAD_C{1'b0}}, cmd_mem[slot]};
            2'd1: bus_rdata = {{PAD_R{1'b0}}, rsel};
            2'd2: bus_rdata = {rsel, {PAD_R{1'b0}}};
            2'd3: bus_rdata = {~rsel[RES_W-1], rsel[RES_W-2:0], {PAD_R{1'b0}}};
        endcase
    end

endmodule

// File: rtl/adcq_queue.sv
module adcq_queue
    import adcq_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  qmode_e         mode,
    input  logic           sw_go,
    input  logic           ext_trig,
    input  logic [IDX_W:0] start_ptr,
    input  logic           adv,
    input  logic           adv_pause,
    input  logic           finish,
    output logic           run,
    output logic [IDX_W:0] ptr,
    output logic           done
);

    qstate_e st, st_nxt;
    logic    trig;

    always_comb begin
        trig   = (mode == MODE_SW && sw_go) || (mode == MODE_EXT && ext_trig);
        st_nxt = st;
        unique case (st)
            QS_IDLE:  if (trig) st_nxt = QS_RUN;
            QS_RUN: begin
                if (finish)                st_nxt = QS_IDLE;
                else if (adv && adv_pause) st_nxt = QS_PAUSE;
            end
            QS_PAUSE: if (trig) st_nxt = QS_RUN;
            default:  st_nxt = QS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= QS_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= '0;
            done <= 1'b0;
        end else begin
            done <= (st == QS_RUN) && finish;
            if (st == QS_IDLE && trig)
                ptr <= start_ptr;
            else if (st == QS_RUN && adv)
                ptr <= ptr + 1'b1;
        end
    end

    assign run = (st == QS_RUN);

endmodule

// File: rtl/adcq_fsm.sv
module adcq_fsm
    import adcq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int RES_W  = 10,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       run,
    input  logic [IDX_W:0]   ptr0,
    input  logic [IDX_W:0]   ptr1,
    input  logic [IDX_W:0]   lim0,
    input  cmd_t             cmd_word,
    output logic [IDX_W-1:0] cmd_idx,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             conv_start,
    output logic [5:0]       conv_chan,
    output logic             conv_ref,
    output logic [1:0]       conv_ist,
    output logic             res_we,
    output logic [IDX_W-1:0] res_idx,
    output logic [RES_W-1:0] res_val,
    output logic [1:0]       adv,
    output logic             adv_pause,
    output logic [1:0]       finish
);

    localparam logic [IDX_W:0] LIM_FULL = (IDX_W + 1)'(DEPTH);

    seq_e             st, st_nxt;
    logic             pick_q, hit_end, issue, any_run;
    logic [IDX_W:0]   pick_ptr, pick_lim;
    logic             cur_q, cur_pause;
    logic [IDX_W-1:0] cur_idx;

    always_comb begin
        any_run  = |run;
        pick_q   = !run[0];
        pick_ptr = pick_q ? ptr1 : ptr0;
        pick_lim = pick_q ? LIM_FULL : lim0;
        cmd_idx  = pick_ptr[IDX_W-1:0];
        hit_end  = (pick_ptr >= pick_lim) || (cmd_word.chan == END_CODE);
        issue    = (st == SQ_PICK) && any_run && !hit_end;
        finish   = ((st == SQ_PICK) && any_run && hit_end)
                   ? (pick_q ? 2'b10 : 2'b01) : 2'b00;
        res_we   = (st == SQ_WAIT) && conv_done;
        res_idx  = cur_idx;
        res_val  = conv_result;
        adv      = res_we ? (cur_q ? 2'b10 : 2'b01) : 2'b00;
        adv_pause = cur_pause;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            SQ_PICK: if (issue)     st_nxt = SQ_WAIT;
            SQ_WAIT: if (conv_done) st_nxt = SQ_PICK;
            default: st_nxt = SQ_PICK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_PICK;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            conv_chan  <= '0;
            conv_ref   <= 1'b0;
            conv_ist   <= '0;
            cur_q      <= 1'b0;
            cur_idx    <= '0;
            cur_pause  <= 1'b0;
        end else begin
            conv_start <= issue;
            if (issue) begin
                conv_chan <= cmd_word.chan;
                conv_ref  <= cmd_word.ref_alt;
                conv_ist  <= cmd_word.ist;
                cur_q     <= pick_q;
                cur_idx   <= cmd_idx;
                cur_pause <= cmd_word.pause;
            end
        end
    end

endmodule

// File: rtl/adcq_seq.sv
module adcq_seq
    import adcq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AW    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        q1_mode,
    input  logic [1:0]        q2_mode,
    input  logic [IDX_W:0]    q2_base,
    input  logic [1:0]        sw_go,
    input  logic [1:0]        ext_trig,
    output logic              conv_start,
    output logic [5:0]        conv_chan,
    output logic              conv_ref,
    output logic [1:0]        conv_ist,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic [1:0]        q_done
);

    localparam logic [IDX_W:0] LIM_FULL = (IDX_W + 1)'(DEPTH);

    qmode_e           mode_a  [2];
    logic [IDX_W:0]   start_a [2];
    logic [IDX_W:0]   ptr_a   [2];
    logic [1:0]       run, adv, finish;
    logic             adv_pause, res_we;
    logic [IDX_W-1:0] cmd_idx, res_idx;
    logic [RES_W-1:0] res_val;
    logic [IDX_W:0]   q2_start;
    cmd_t             cmd_word;

    assign q2_start   = (q2_base >= LIM_FULL) ? LIM_FULL : q2_base;
    assign mode_a[0]  = qmode_e'(q1_mode);
    assign mode_a[1]  = qmode_e'(q2_mode);
    assign start_a[0] = '0;
    assign start_a[1] = q2_start;

    adcq_store #(.DEPTH(DEPTH), .RES_W(RES_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cmd_idx(cmd_idx), .cmd_word(cmd_word),
        .res_we(res_we), .res_idx(res_idx), .res_val(res_val)
    );

    for (genvar g = 0; g < 2; g++) begin : g_q
        adcq_queue #(.DEPTH(DEPTH)) queue_i (
            .clk(clk), .rst_n(rst_n),
            .mode(mode_a[g]), .sw_go(sw_go[g]), .ext_trig(ext_trig[g]),
            .start_ptr(start_a[g]),
            .adv(adv[g]), .adv_pause(adv_pause), .finish(finish[g]),
            .run(run[g]), .ptr(ptr_a[g]), .done(q_done[g])
        );
    end

    adcq_fsm #(.DEPTH(DEPTH), .RES_W(RES_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .run(run), .ptr0(ptr_a[0]), .ptr1(ptr_a[1]), .lim0(q2_start),
        .cmd_word(cmd_word), .cmd_idx(cmd_idx),
        .conv_done(conv_done), .conv_result(conv_result),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_ref(conv_ref), .conv_ist(conv_ist),
        .res_we(res_we), .res_idx(res_idx), .res_val(res_val),
        .adv(adv), .adv_pause(adv_pause), .finish(finish)
    );

endmodule

// File: rtl/adcq_seq_chk.sv
module adcq_seq_chk
    import adcq_pkg::*;
#(
    parameter int AW     = 8,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              conv_start,
    input logic              conv_done,
    input logic [1:0]        q_done
);

    logic waiting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          waiting <= 1'b0;
        else if (conv_start) waiting <= 1'b1;
        else if (conv_done)  waiting <= 1'b0;
    end

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !waiting);

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R7
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_done));

    // R7
    done0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_done[0] |=> !q_done[0]);

    // R7
    done1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_done[1] |=> !q_done[1]);

    // R1
    cmd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[AW-1:AW-2] == 2'd0) |-> (bus_rdata[DATA_W-1:CMD_W] == '0));

    // R5
    left_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[AW-1] |-> (bus_rdata[DATA_W-RES_W-1:0] == '0));

endmodule

bind adcq_seq adcq_seq_chk #(.AW(AW), .RES_W(RES_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .conv_start(conv_start), .conv_done(conv_done), .q_done(q_done)
);

// File: tb/adcq_seq_tb_top.sv
module adcq_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  q1_mode = 2'd0;
    logic [1:0]  q2_mode = 2'd0;
    logic [6:0]  q2_base = 7'd64;
    logic [1:0]  sw_go = '0;
    logic [1:0]  ext_trig = '0;
    logic        conv_start;
    logic [5:0]  conv_chan;
    logic        conv_ref;
    logic [1:0]  conv_ist;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_result = '0;
    logic [1:0]  q_done;

    int n_chk = 0;
    int n_bad = 0;
    int last_ref = 0;
    int last_ist = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adcq_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .q1_mode(q1_mode), .q2_mode(q2_mode), .q2_base(q2_base),
        .sw_go(sw_go), .ext_trig(ext_trig),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_ref(conv_ref), .conv_ist(conv_ist),
        .conv_done(conv_done), .conv_result(conv_result),
        .q_done(q_done)
    );

    function automatic int res_of(input int ch);
        return (ch * 16 + 5) & 1023;
    endfunction

    function automatic int cmdw(input int p, input int r, input int ist, input int ch);
        return (p << 9) | (r << 8) | (ist << 6) | ch;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr[7:0]; bus_wdata = data[15:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output int v);
        @(negedge clk);
        bus_addr = addr[7:0];
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic trig(input logic [1:0] sw, input logic [1:0] ext);
        @(negedge clk);
        sw_go = sw; ext_trig = ext;
        @(negedge clk);
        sw_go = '0; ext_trig = '0;
    endtask

    task automatic serve(input string req, input int exp_chan);
        int n = 0;
        while (!conv_start && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (!conv_start) begin
            chk({req, " start missing"}, 0, 1);
            return;
        end
        chk({req, " channel"}, int'(conv_chan), exp_chan);
        last_ref = int'(conv_ref);
        last_ist = int'(conv_ist);
        @(negedge clk);
        chk("R10 no start while busy", int'(conv_start), 0);
        @(negedge clk);
        conv_done = 1'b1;
        conv_result = 10'(res_of(exp_chan));
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic quiet(input string req, input int cycles);
        int starts = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_start) starts++;
        end
        chk({req, " no start"}, starts, 0);
    endtask

    task automatic wait_done(input int q, input string req);
        int seen = 0;
        int starts = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (q_done[q]) seen++;
            if (conv_start) starts++;
        end
        chk({req, " completion pulse"}, seen, 1);
        chk({req, " no start after end"}, starts, 0);
    endtask

    task automatic check_result(input int idx, input int ch, input string req);
        int v;
        int r = res_of(ch);
        rd(64 + idx, v);  chk({req, " right unsigned"}, v, r);
        rd(128 + idx, v); chk({req, " left unsigned"}, v, (r << 6) & 16'hFFFF);
        rd(192 + idx, v); chk({req, " left signed"}, v, ((r ^ 512) << 6) & 16'hFFFF);
    endtask

    task automatic t_reset();
        int v;
        chk("R11 conv_start after reset", int'(conv_start), 0);
        chk("R11 q_done after reset", int'(q_done), 0);
        rd(0, v);  chk("R11 command slot zero", v, 0);
        rd(69, v); chk("R11 result slot zero", v, 0);
    endtask

    task automatic t_cmd_rw();
        int v;
        wr(5, 16'hFFFF);
        rd(5, v); chk("R1 command readback masked", v, 16'h03FF);
        wr(5, 16'h0000);
    endtask

    task automatic t_single_scan();
        int v;
        q1_mode = 2'd1; q2_mode = 2'd0; q2_base = 7'd64;
        wr(0, cmdw(0, 1, 2, 10));
        wr(1, cmdw(0, 0, 1, 40));
        wr(2, cmdw(0, 0, 0, 20));
        wr(3, cmdw(0, 0, 0, 63));
        trig(2'b01, 2'b00);
        serve("R4 slot0", 10);
        chk("R4 reference field", last_ref, 1);
        chk("R4 sample-time field", last_ist, 2);
        serve("R4 slot1", 40);
        chk("R4 sample-time slot1", last_ist, 1);
        serve("R4 slot2", 20);
        wait_done(0, "R7 end code");
        check_result(0, 10, "R5 slot0");
        check_result(1, 40, "R5 slot1");
        check_result(2, 20, "R5 slot2");
        wr(65, 16'h1234);
        wr(129, 16'h1234);
        wr(193, 16'h1234);
        rd(65, v); chk("R2 result write ignored", v, res_of(40));
        rd(1, v);  chk("R2 command untouched", v, cmdw(0, 0, 1, 40));
    endtask

    task automatic t_pause();
        wr(0, cmdw(1, 0, 0, 3));
        wr(1, cmdw(0, 0, 0, 4));
        wr(2, cmdw(0, 0, 0, 63));
        trig(2'b01, 2'b00);
        serve("R6 pause command", 3);
        quiet("R6 paused", 20);
        chk("R6 no completion while paused", int'(q_done), 0);
        trig(2'b01, 2'b00);
        serve("R6 resumed slot", 4);
        wait_done(0, "R6 end after resume");
    endtask

    task automatic t_modes();
        wr(0, cmdw(0, 0, 0, 9));
        wr(1, cmdw(0, 0, 0, 63));
        q1_mode = 2'd2;
        trig(2'b01, 2'b00);
        quiet("R3 external mode ignores software", 15);
        trig(2'b00, 2'b01);
        serve("R3 external trigger", 9);
        wait_done(0, "R3 external scan");
        q1_mode = 2'd0;
        trig(2'b01, 2'b01);
        quiet("R3 disabled queue", 15);
        q1_mode = 2'd1;
        trig(2'b00, 2'b01);
        quiet("R3 software mode ignores external", 15);
    endtask

    task automatic t_split();
        q1_mode = 2'd1; q2_mode = 2'd1; q2_base = 7'd2;
        wr(0, cmdw(0, 0, 0, 5));
        wr(1, cmdw(0, 0, 0, 6));
        wr(2, cmdw(0, 0, 0, 7));
        wr(3, cmdw(0, 0, 0, 63));
        trig(2'b01, 2'b00);
        serve("R8 first queue slot0", 5);
        serve("R8 first queue slot1", 6);
        wait_done(0, "R8 first queue stops at second base");
        trig(2'b10, 2'b00);
        serve("R8 second queue first slot", 7);
        wait_done(1, "R8 second queue end");
        check_result(2, 7, "R5 second queue slot");
    endtask

    task automatic t_whole();
        for (int i = 0; i < 64; i++) wr(i, cmdw(0, 0, 0, (i * 7) % 62));
        q1_mode = 2'd0; q2_mode = 2'd1; q2_base = 7'd0;
        trig(2'b10, 2'b00);
        for (int i = 0; i < 64; i++) serve("R8 second queue whole table", (i * 7) % 62);
        wait_done(1, "R8 second queue past slot 63");
        check_result(63, (63 * 7) % 62, "R5 slot63");
        q1_mode = 2'd1; q2_mode = 2'd0; q2_base = 7'd100;
        trig(2'b01, 2'b00);
        for (int i = 0; i < 64; i++) serve("R8 first queue whole table", (i * 7) % 62);
        wait_done(0, "R8 first queue past slot 63");
    endtask

    task automatic t_priority();
        q1_mode = 2'd1; q2_mode = 2'd1; q2_base = 7'd4;
        wr(0, cmdw(0, 0, 0, 1));
        wr(1, cmdw(0, 0, 0, 2));
        wr(2, cmdw(0, 0, 0, 63));
        wr(4, cmdw(0, 0, 0, 30));
        wr(5, cmdw(0, 0, 0, 63));
        trig(2'b11, 2'b00);
        serve("R9 first queue goes first", 1);
        serve("R9 first queue second", 2);
        serve("R9 second queue after", 30);
        wait_done(1, "R9 second queue end");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_rw();
        t_single_scan();
        t_pause();
        t_modes();
        t_split();
        t_whole();
        t_priority();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule